// File: doc/BRIEF.md
# Configuration Access Port Bridge

This block gives a host a two-register window for reaching PCI configuration space on a single bus. The window is eight bytes wide. Its lower dword holds a latched configuration address. Its upper dword is a data port that reads or writes the dword that the latched address names. The host bus carries byte, halfword and word accesses. The address register can therefore be built up from narrow writes, and any byte of a configuration dword can be read or written on its own.

The latched address is split into an enable flag, a bus number, a device number, a function number and a dword register index. Device 0 is the bridge's own small configuration header, which describes a host bridge. Device k, from 1 to `N_PORTS`, reaches downstream port k-1 over a request/response handshake, and the host access completes only when that port answers. Every other combination answers with all ones and writes nothing: a cleared enable bit, a bus other than 0, an unpopulated slot, an access that crosses a dword boundary, or an offset outside the window. The block also drives a fixed legacy interrupt-pin code for each downstream slot.

Top module: `cfg_access_bridge`

## Requirements
- R1: Host offsets 0 to 3 reach the address register and offsets 4 to 7 reach the data port. Offsets 8 to 15 read as all ones in the requested width, and writes to them change nothing.
- R2: The address register is decoded as follows: enable = bit 31, bus = bits 23:16, device = bits 15:11, function = bits 10:8, dword register index = bits 7:2. The function field never changes which target is selected.
- R3: Byte lanes are little-endian: host_off[1:0] is the starting lane, and write data comes in at bit 0. A narrow address write changes only its own lanes. Read data is returned shifted down to bit 0, with zeros above the requested width.
- R4: host_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is reserved. An access whose start lane plus its length goes past 4, or that uses size 3, reads as all ones in the requested width (32 ones for size 3) and writes nothing.
- R5: When the enable bit is clear or the bus number is not 0, a data read returns all ones in the requested width, a data write is dropped, and no downstream port is requested.
- R6: Device 0 reaches the bridge header. Dword 0 reads 0x0C01FACE (device ID in the upper half, vendor ID in the lower). Dword 2 reads 0x06000000 (bridge class, host subclass). Dword 3 bits 23:16 read 0x01 (bridge header layout). Dword 1 bits 15:0 (command) and dword 3 bits 7:0 (line size) are writable per lane and reset to 0. Every other field reads 0 and ignores writes.
- R7: Device k with 1 <= k <= N_PORTS raises only dn_req[k-1]. The request carries the register index, the lane enables and the lane-aligned write data, and it is held until dn_rsp[k-1]. The host is acknowledged only after that response. A device number above N_PORTS reads as all ones.
- R8: slot_pin[2i+1:2i] equals i mod 4, where 0 to 3 stand for INTA to INTD.
- R9: Reset clears the address register to 0. host_ack is a one-cycle pulse. A host access that needs no downstream port is acknowledged in the cycle after it is accepted. host_req is held until host_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 4 | Byte offset within the I/O window |
| host_size | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| host_wdata | input | 32 | Write data, least significant byte first |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ack |
| dn_req | output | N_PORTS | One-hot downstream request, held until response |
| dn_we | output | 1 | Downstream write flag |
| dn_reg | output | 6 | Downstream dword register index |
| dn_be | output | 4 | Downstream byte-lane enables |
| dn_wdata | output | 32 | Downstream lane-aligned write data |
| dn_rsp | input | N_PORTS | Per-port response pulse |
| dn_rdata | input | 32*N_PORTS | Per-port read data, valid with response |
| slot_pin | output | 2*N_PORTS | Interrupt-pin code per downstream slot |

## Verification
Two functions can act in the same clock edge. The first is the narrow-write merge into the address register. The second is the decode that the very next data access routes on. The bench writes one lane of the address and follows it at once with a data access. It judges that the access went to the target named by the merged word, not the old one. A second overlap is a port response arriving in the edge where its request must drop while the host still holds host_req. Downstream models with different latencies, including the shortest, provoke it. The bench judges it by port contents after read-back: a doubled or lost write, or a second acceptance, would show there.

// File: rtl/cab_pkg.sv
package cab_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } cab_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] regi;
    } cab_addr_t;

    // Split a latched address word into its fields.
    function automatic cab_addr_t cab_decode(input logic [31:0] a);
        cab_addr_t f;
        f.en   = a[31];
        f.bus  = a[23:16];
        f.dev  = a[15:11];
        f.fn   = a[10:8];
        f.regi = a[7:2];
        return f;
    endfunction

    // True when the access stays inside one dword.
    function automatic logic cab_fits(input logic [1:0] size, input logic [1:0] start);
        case (size)
            2'd0:    return 1'b1;
            2'd1:    return start != 2'd3;
            2'd2:    return start == 2'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] cab_lanes(input logic [1:0] size, input logic [1:0] start);
        logic [3:0] base;
        case (size)
            2'd0:    base = 4'b0001;
            2'd1:    base = 4'b0011;
            2'd2:    base = 4'b1111;
            default: base = 4'b0000;
        endcase
        return base << start;
    endfunction

    function automatic logic [31:0] cab_width_ones(input logic [1:0] size);
        case (size)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] cab_extract(input logic [31:0] v, input logic [1:0] start,
                                                input logic [1:0] size);
        return (v >> {start, 3'b000}) & cab_width_ones(size);
    endfunction

    function automatic logic [31:0] cab_place(input logic [31:0] v, input logic [1:0] start);
        return v << {start, 3'b000};
    endfunction

endpackage

// File: rtl/cab_addr_reg.sv
module cab_addr_reg
    import cab_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] addr_o,
    output cab_addr_t   fields_o
);

    typedef struct packed {
        logic [31:0] addr;
    } areg_t;

    areg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) st_d.addr[8*b +: 8] = wdata[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o   = st_q.addr;
    assign fields_o = cab_decode(st_q.addr);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(addr_o));

    // R3
    upper_lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !be[3]) |=> addr_o[31:24] == $past(addr_o[31:24]));

endmodule

// File: rtl/cab_host_cfg.sv
module cab_host_cfg #(
    parameter logic [15:0] VENDOR_ID = 16'hFACE,
    parameter logic [15:0] DEVICE_ID = 16'h0C01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  idx,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);

    localparam logic [7:0] CLASS_BRIDGE = 8'h06;
    localparam logic [7:0] SUB_HOST     = 8'h00;
    localparam logic [7:0] HDR_BRIDGE   = 8'h01;

    typedef struct packed {
        logic [15:0] cmd;
        logic [7:0]  line_sz;
    } hcfg_t;

    hcfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (idx == 6'd1) begin
                if (be[0]) st_d.cmd[7:0]  = wdata[7:0];
                if (be[1]) st_d.cmd[15:8] = wdata[15:8];
            end
            if (idx == 6'd3 && be[0]) st_d.line_sz = wdata[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (idx)
            6'd0:    rdata = {DEVICE_ID, VENDOR_ID};
            6'd1:    rdata = {16'h0000, st_q.cmd};
            6'd2:    rdata = {CLASS_BRIDGE, SUB_HOST, 16'h0000};
            6'd3:    rdata = {8'h00, HDR_BRIDGE, 8'h00, st_q.line_sz};
            default: rdata = 32'h0;
        endcase
    end

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.cmd));

    // R6
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx != 6'd3) |=> $stable(st_q.line_sz));

endmodule

// File: rtl/cab_slot_pins.sv
module cab_slot_pins #(
    parameter int N_PORTS = 5
) (
    output logic [2*N_PORTS-1:0] slot_pin
);

    for (genvar i = 0; i < N_PORTS; i++) begin : g_pin
        localparam logic [1:0] PIN_CODE = 2'(i % 4);
        assign slot_pin[2*i +: 2] = PIN_CODE;
    end

endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
    import cab_pkg::*;
#(
    parameter int          N_PORTS   = 5,
    parameter logic [15:0] VENDOR_ID = 16'hFACE,
    parameter logic [15:0] DEVICE_ID = 16'h0C01
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic                   host_we,
    input  logic [3:0]             host_off,
    input  logic [1:0]             host_size,
    input  logic [31:0]            host_wdata,
    output logic                   host_ack,
    output logic [31:0]            host_rdata,
    output logic [N_PORTS-1:0]     dn_req,
    output logic                   dn_we,
    output logic [5:0]             dn_reg,
    output logic [3:0]             dn_be,
    output logic [31:0]            dn_wdata,
    input  logic [N_PORTS-1:0]     dn_rsp,
    input  logic [32*N_PORTS-1:0]  dn_rdata,
    output logic [2*N_PORTS-1:0]   slot_pin
);

    localparam logic [N_PORTS-1:0] ONE_HOT0 = N_PORTS'(1);

    typedef struct packed {
        cab_state_e         st;
        logic               ack;
        logic [31:0]        rdata;
        logic [N_PORTS-1:0] req;
        logic               we;
        logic [5:0]         regi;
        logic [3:0]         be;
        logic [31:0]        wdata;
        logic [1:0]         start;
        logic [1:0]         size;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [31:0] addr_q;
    cab_addr_t   fields;
    logic [31:0] hcfg_rdata;
    logic        addr_wr, hcfg_wr;
    logic        accept, fit, in_addr, in_data, route_ok, port_ok;
    logic [1:0]  start;
    logic [3:0]  lanes;
    logic [31:0] wd_al, ones, sel_rdata;
    logic [4:0]  pidx;

    cab_addr_reg u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (addr_wr),
        .be      (lanes),
        .wdata   (wd_al),
        .addr_o  (addr_q),
        .fields_o(fields)
    );

    cab_host_cfg #(
        .VENDOR_ID(VENDOR_ID),
        .DEVICE_ID(DEVICE_ID)
    ) u_hcfg (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(hcfg_wr),
        .idx  (fields.regi),
        .be   (lanes),
        .wdata(wd_al),
        .rdata(hcfg_rdata)
    );

    cab_slot_pins #(.N_PORTS(N_PORTS)) u_pins (
        .slot_pin(slot_pin)
    );

    // Response data from whichever port holds the request.
    always_comb begin
        sel_rdata = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (ctl_q.req[p]) sel_rdata = sel_rdata | dn_rdata[32*p +: 32];
        end
    end

    always_comb begin
        start    = host_off[1:0];
        fit      = cab_fits(host_size, start);
        lanes    = cab_lanes(host_size, start);
        wd_al    = cab_place(host_wdata, start);
        ones     = cab_width_ones(host_size);
        in_addr  = host_off[3:2] == 2'b00;
        in_data  = host_off[3:2] == 2'b01;
        route_ok = fields.en && (fields.bus == 8'h00);
        port_ok  = (fields.dev != 5'd0) && (int'(fields.dev) <= N_PORTS);
        pidx     = fields.dev - 5'd1;
        accept   = host_req && !ctl_q.ack && (ctl_q.st == ST_IDLE);

        ctl_d    = ctl_q;
        ctl_d.ack = 1'b0;
        addr_wr  = 1'b0;
        hcfg_wr  = 1'b0;

        if (accept) begin
            ctl_d.ack   = 1'b1;
            ctl_d.rdata = host_we ? 32'h0 : ones;
            if (fit && in_addr) begin
                if (host_we) addr_wr = 1'b1;
                else         ctl_d.rdata = cab_extract(addr_q, start, host_size);
            end else if (fit && in_data && route_ok) begin
                if (fields.dev == 5'd0) begin
                    if (host_we) hcfg_wr = 1'b1;
                    else         ctl_d.rdata = cab_extract(hcfg_rdata, start, host_size);
                end else if (port_ok) begin
                    ctl_d.ack   = 1'b0;
                    ctl_d.st    = ST_WAIT;
                    ctl_d.req   = ONE_HOT0 << pidx;
                    ctl_d.we    = host_we;
                    ctl_d.regi  = fields.regi;
                    ctl_d.be    = lanes;
                    ctl_d.wdata = wd_al;
                    ctl_d.start = start;
                    ctl_d.size  = host_size;
                end
            end
        end else if (ctl_q.st == ST_WAIT && (|(dn_rsp & ctl_q.req))) begin
            ctl_d.ack   = 1'b1;
            ctl_d.rdata = ctl_q.we ? 32'h0 : cab_extract(sel_rdata, ctl_q.start, ctl_q.size);
            ctl_d.req   = '0;
            ctl_d.st    = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign host_ack   = ctl_q.ack;
    assign host_rdata = ctl_q.rdata;
    assign dn_req     = ctl_q.req;
    assign dn_we      = ctl_q.we;
    assign dn_reg     = ctl_q.regi;
    assign dn_be      = ctl_q.be;
    assign dn_wdata   = ctl_q.wdata;

    // R7
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_req));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dn_req) && !(|(dn_req & dn_rsp))) |=> (dn_req == $past(dn_req)));

    // R7
    ack_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ack && (|dn_req)));

    // R7
    lanes_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dn_req) |-> (dn_be != 4'b0000));

    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R5
    disabled_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_data && !route_ok) |=> (dn_req == '0));

endmodule

// File: tb/tb_cfg_access_bridge.sv
module tb_cfg_access_bridge;

    localparam int N = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_req = 1'b0;
    logic              host_we = 1'b0;
    logic [3:0]        host_off = 4'd0;
    logic [1:0]        host_size = 2'd0;
    logic [31:0]       host_wdata = 32'h0;
    logic              host_ack;
    logic [31:0]       host_rdata;
    logic [N-1:0]      dn_req;
    logic              dn_we;
    logic [5:0]        dn_reg;
    logic [3:0]        dn_be;
    logic [31:0]       dn_wdata;
    logic [N-1:0]      dn_rsp;
    logic [32*N-1:0]   dn_rdata;
    logic [2*N-1:0]    slot_pin;

    int tests = 0;
    int fails = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    cfg_access_bridge #(.N_PORTS(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_off(host_off),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata),
        .dn_req(dn_req), .dn_we(dn_we), .dn_reg(dn_reg), .dn_be(dn_be),
        .dn_wdata(dn_wdata), .dn_rsp(dn_rsp), .dn_rdata(dn_rdata),
        .slot_pin(slot_pin)
    );

    function automatic logic [31:0] seed_word(input int p, input int r);
        return {8'(p + 1), 8'(r), 16'hC0DE};
    endfunction

    // Downstream port models, latency p % 3 extra cycles.
    logic [31:0] pmem [N][64];
    int          pcnt [N];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < N; p++) begin
                for (int r = 0; r < 64; r++) pmem[p][r] <= seed_word(p, r);
                pcnt[p] <= 0;
            end
            dn_rsp   <= '0;
            dn_rdata <= '0;
        end else begin
            for (int p = 0; p < N; p++) begin
                dn_rsp[p] <= 1'b0;
                if (dn_req[p] && !dn_rsp[p]) begin
                    if (pcnt[p] == p % 3) begin
                        dn_rsp[p] <= 1'b1;
                        pcnt[p]   <= 0;
                        dn_rdata[32*p +: 32] <= pmem[p][dn_reg];
                        if (dn_we) begin
                            for (int b = 0; b < 4; b++)
                                if (dn_be[b]) pmem[p][dn_reg][8*b +: 8] <= dn_wdata[8*b +: 8];
                        end
                    end else begin
                        pcnt[p] <= pcnt[p] + 1;
                    end
                end
            end
        end
    end

    // Expected-state shadows kept from the requirements.
    logic [31:0] exp_mem [N][64];
    logic [31:0] addr_sh = 32'h0;
    logic [15:0] cmd_sh = 16'h0;
    logic [7:0]  cls_sh = 8'h0;

    function automatic logic b_fit(input int sz, input int st);
        if (sz == 0) return 1'b1;
        if (sz == 1) return st <= 2;
        if (sz == 2) return st == 0;
        return 1'b0;
    endfunction

    function automatic logic [31:0] b_ones(input int sz);
        if (sz == 0) return 32'hFF;
        if (sz == 1) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic int b_len(input int sz);
        if (sz == 0) return 1;
        if (sz == 1) return 2;
        return 4;
    endfunction

    function automatic logic [31:0] b_get(input logic [31:0] v, input int st, input int sz);
        return (v >> (8 * st)) & b_ones(sz);
    endfunction

    function automatic logic [31:0] b_bridge(input int r);
        case (r)
            0:       return 32'h0C01_FACE;
            1:       return {16'h0, cmd_sh};
            2:       return 32'h0600_0000;
            3:       return {8'h00, 8'h01, 8'h00, cls_sh};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] b_data_read(input int st, input int sz);
        int dev, r;
        dev = int'(addr_sh[15:11]);
        r   = int'(addr_sh[7:2]);
        if (!b_fit(sz, st)) return b_ones(sz);
        if (!addr_sh[31] || addr_sh[23:16] != 8'h00) return b_ones(sz);
        if (dev == 0) return b_get(b_bridge(r), st, sz);
        if (dev <= N) return b_get(exp_mem[dev-1][r], st, sz);
        return b_ones(sz);
    endfunction

    task automatic b_data_write(input int st, input int sz, input logic [31:0] wd);
        int dev, r;
        logic [31:0] al;
        dev = int'(addr_sh[15:11]);
        r   = int'(addr_sh[7:2]);
        al  = wd << (8 * st);
        if (!b_fit(sz, st) || !addr_sh[31] || addr_sh[23:16] != 8'h00) return;
        for (int b = st; b < st + b_len(sz); b++) begin
            if (dev == 0) begin
                if (r == 1 && b < 2) cmd_sh[8*b +: 8] = al[8*b +: 8];
                if (r == 3 && b == 0) cls_sh = al[7:0];
            end else if (dev <= N) begin
                exp_mem[dev-1][r][8*b +: 8] = al[8*b +: 8];
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input int off, input int sz, input logic [31:0] wd,
                       output logic [31:0] rd, output int cyc);
        @(negedge clk);
        host_req   = 1'b1;
        host_we    = we;
        host_off   = 4'(off);
        host_size  = 2'(sz);
        host_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!host_ack && cyc < 1000);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic set_addr(input logic [31:0] a);
        logic [31:0] rd;
        int cyc;
        acc(1'b1, 0, 2, a, rd, cyc);
        addr_sh = a;
    endtask

    function automatic logic [31:0] mk_addr(input int en, input int bus, input int dev,
                                            input int fn, input int r);
        return {1'(en), 7'b0, 8'(bus), 5'(dev), 3'(fn), 6'(r), 2'b00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog expired act=%0d exp=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        int bus_list [3];
        int reg_list [5];
        int wreg_list [3];
        bus_list  = '{0, 1, 128};
        reg_list  = '{0, 1, 2, 3, 9};
        wreg_list = '{1, 3, 6};
        for (int p = 0; p < N; p++)
            for (int r = 0; r < 64; r++) exp_mem[p][r] = seed_word(p, r);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R9), disabled read (R5), pin codes (R8)
        chk("R9 ack idle after reset", {31'b0, host_ack}, 32'h0);
        chk("R7 no request after reset", 32'(dn_req), 32'h0);
        acc(1'b0, 0, 2, 32'h0, rd, cyc);
        chk("R9 address cleared by reset", rd, 32'h0);
        chk("R9 local ack latency", 32'(cyc), 32'd1);
        acc(1'b0, 4, 2, 32'h0, rd, cyc);
        chk("R5 read with enable clear", rd, 32'hFFFF_FFFF);
        for (int i = 0; i < N; i++)
            chk("R8 slot pin code", 32'(slot_pin[2*i +: 2]), 32'(i % 4));

        // Address register lanes: R3, R4
        for (int sz = 0; sz < 4; sz++) begin
            for (int st = 0; st < 4; st++) begin
                logic [31:0] wd, nw;
                set_addr(32'h1357_9BDF);
                wd = 32'hA0B1_C2D3 ^ 32'(sz * 16 + st);
                acc(1'b1, st, sz, wd, rd, cyc);
                chk("R9 local write ack latency", 32'(cyc), 32'd1);
                nw = addr_sh;
                if (b_fit(sz, st))
                    for (int b = st; b < st + b_len(sz); b++) nw[8*b +: 8] = wd[8*(b-st) +: 8];
                addr_sh = nw;
                acc(1'b0, 0, 2, 32'h0, rd, cyc);
                chk("R3 address lane merge", rd, addr_sh);
                acc(1'b0, st, sz, 32'h0, rd, cyc);
                chk("R4 address narrow read",
                    rd, b_fit(sz, st) ? b_get(addr_sh, st, sz) : b_ones(sz));
            end
        end

        // Routing sweep: R2, R5, R6, R7 (function field 5 must not change target)
        for (int en = 0; en < 2; en++)
            for (int bi = 0; bi < 3; bi++)
                for (int dev = 0; dev < 8; dev++)
                    for (int fi = 0; fi < 2; fi++)
                        for (int ri = 0; ri < 5; ri++) begin
                            set_addr(mk_addr(en, bus_list[bi], dev, fi * 5, reg_list[ri]));
                            acc(1'b0, 4, 2, 32'h0, rd, cyc);
                            chk("R2 R5 R6 R7 routed word read", rd, b_data_read(0, 2));
                        end

        // Narrow and misaligned data reads: R3, R4
        for (int dev = 0; dev < 4; dev += 3)
            for (int sz = 0; sz < 4; sz++)
                for (int st = 0; st < 4; st++) begin
                    set_addr(mk_addr(1, 0, dev, 0, dev == 0 ? 0 : 7));
                    acc(1'b0, 4 + st, sz, 32'h0, rd, cyc);
                    chk("R4 data narrow read", rd, b_data_read(st, sz));
                end

        // Address lane rewrite followed at once by a data access: R2, R3
        set_addr(mk_addr(1, 0, 2, 0, 4));
        acc(1'b1, 1, 0, 32'h0000_0020, rd, cyc);
        addr_sh[15:8] = 8'h20;
        acc(1'b0, 4, 2, 32'h0, rd, cyc);
        chk("R3 merged address routes next access", rd, b_data_read(0, 2));

        // Write sweep: R5, R6, R7
        for (int dev = 0; dev < N + 2; dev++)
            for (int wi = 0; wi < 3; wi++)
                for (int sz = 0; sz < 4; sz++)
                    for (int st = 0; st < 4; st++)
                        for (int en = 0; en < 2; en++) begin
                            logic [31:0] wd;
                            wd = 32'h5A00_0000 ^ 32'(dev * 256 + wi * 64 + sz * 16 + st * 2 + en);
                            set_addr(mk_addr(en, 0, dev, 0, wreg_list[wi]));
                            acc(1'b1, 4 + st, sz, wd, rd, cyc);
                            b_data_write(st, sz, wd);
                            set_addr(mk_addr(1, 0, dev, 0, wreg_list[wi]));
                            acc(1'b0, 4, 2, 32'h0, rd, cyc);
                            chk("R5 R6 R7 write then read back", rd, b_data_read(0, 2));
                        end
        set_addr(mk_addr(1, 0, 0, 0, 0));
        acc(1'b1, 4, 2, 32'h1111_2222, rd, cyc);
        acc(1'b0, 4, 2, 32'h0, rd, cyc);
        chk("R6 identity dword read only", rd, 32'h0C01_FACE);

        // Outside the window: R1
        set_addr(mk_addr(1, 0, 1, 0, 2));
        for (int off = 8; off < 16; off++) begin
            acc(1'b1, off, 0, 32'h0000_0077, rd, cyc);
            acc(1'b0, off, 2, 32'h0, rd, cyc);
            chk("R1 outside word read", rd, 32'hFFFF_FFFF);
            acc(1'b0, off, 0, 32'h0, rd, cyc);
            chk("R1 outside byte read", rd, 32'h0000_00FF);
        end
        acc(1'b0, 0, 2, 32'h0, rd, cyc);
        chk("R1 outside writes leave address", rd, addr_sh);
        acc(1'b0, 4, 2, 32'h0, rd, cyc);
        chk("R1 outside writes leave port", rd, b_data_read(0, 2));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule